// File: doc/BRIEF.md
# Hybrid Cache Line Migration Tracker

This block keeps a small 2-bit placement state for every line of a last-level cache that is split into a fast-write SRAM region and a dense, slow-write STT-RAM region. It watches two event streams from the private caches: miss fills and writebacks. Each event carries a set index, a way number and a region bit. From these events it decides which STT-RAM lines receive repeated writebacks. Those lines are moved into the SRAM region before the next writeback lands on them.

A miss fill reserves an STT-RAM line without data. The first writeback to that line marks it as a candidate. A second writeback to the candidate stalls the writeback path and raises a move request. The request names the set, the STT-RAM source way and an SRAM destination way, which is picked round-robin within the set. When the external data mover reports completion, the source line is released and the destination is marked as moved. The stalled writeback then resumes into the SRAM way. The block moves no data itself. A query port returns the state of any line.

Top module: `hybrid_mig_tracker`

## Requirements
- R1: After reset, every line reads state 2'b00 (untracked). `busy`, `mig_req` and `wb_go` are low.
- R2: An accepted fill with region 0 (STT-RAM) and an in-range way sets that line to 2'b01 (reserved, no data). A fill with region 1 (SRAM) changes no state.
- R3: An accepted writeback to an STT-RAM line in state 2'b01 sets the line to 2'b10 (candidate). In the next cycle, `wb_go` pulses for one cycle with the same set, region and way.
- R4: An accepted writeback to an STT-RAM line in state 2'b10 does not change any state. In the next cycle, `busy` and `mig_req` are high, with `mig_set` and `mig_src_way` taken from the writeback. No `wb_go` appears while the move is pending, and the move fields stay stable.
- R5: Each set keeps its own destination pointer. The first move in a set targets SRAM way 0. Each completed move in that set advances the pointer by one, and it wraps to 0 after way SRAM_WAYS-1.
- R6: If `mig_done` is high while a move is pending, then in the next cycle: the SRAM destination line reads 2'b11 (moved), the STT-RAM source line reads 2'b00, `busy` and `mig_req` are low, and `wb_go` pulses with region 1 and the destination way.
- R7: A writeback to a line in state 2'b11 leaves it at 2'b11. The writeback passes through on `wb_go` to the same line.
- R8: While `busy` is high, fill and writeback inputs are not accepted and change no state. A writeback held valid through the stall is accepted in the first cycle after `busy` falls.
- R9: A writeback to an untracked STT-RAM line, or to an SRAM line that is not in state 2'b11, leaves the state unchanged. It still passes through on `wb_go` to the same line.
- R10: A `mig_done` pulse while no move is pending has no effect.
- R11: A writeback whose way is not below the way count of its region (STT_WAYS for region 0, SRAM_WAYS for region 1) changes no state and produces no `wb_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | Miss-fill event valid |
| fill_set | input | SET_W | Set index of the fill |
| fill_way | input | WAY_W | Way of the fill |
| fill_region | input | 1 | Region of the fill (0 STT-RAM, 1 SRAM) |
| wb_valid | input | 1 | Writeback event valid; hold it while `busy` is high |
| wb_set | input | SET_W | Set index of the writeback |
| wb_way | input | WAY_W | Way of the writeback |
| wb_region | input | 1 | Region of the writeback |
| busy | output | 1 | Events are held, because a move is pending |
| mig_req | output | 1 | Move request to the data mover |
| mig_set | output | SET_W | Set of the move |
| mig_src_way | output | WAY_W | STT-RAM source way |
| mig_dst_way | output | WAY_W | SRAM destination way |
| mig_done | input | 1 | Data mover has finished the move |
| wb_go | output | 1 | One-cycle pulse: the writeback may be written now |
| wb_go_set | output | SET_W | Set for the writeback |
| wb_go_region | output | 1 | Region for the writeback |
| wb_go_way | output | WAY_W | Way for the writeback |
| qry_set | input | SET_W | Query set |
| qry_region | input | 1 | Query region |
| qry_way | input | WAY_W | Query way |
| qry_state | output | 2 | State of the queried line |

## Verification
The hardest situation to reach from the ports is an STT-RAM line moving while other events compete with it. A line must first be walked through a fill and two writebacks. The bench then keeps `mig_done` low while it offers a fill to one line and holds a writeback to another. This shows that neither event is taken during the stall, and that the held writeback is accepted in the very next cycle after the move completes. A sweep moves every STT-RAM way of every set, so each set's destination pointer wraps and already-moved SRAM lines are overwritten.

// File: rtl/hmt_pkg.sv
package hmt_pkg;

    typedef enum logic [1:0] {
        LN_NONE   = 2'b00,
        LN_HOLLOW = 2'b01,
        LN_HOT    = 2'b10,
        LN_MOVED  = 2'b11
    } line_st_t;

    typedef enum logic {
        CT_IDLE = 1'b0,
        CT_MOVE = 1'b1
    } ctl_st_t;

    localparam logic RG_STT  = 1'b0;
    localparam logic RG_SRAM = 1'b1;

    function automatic line_st_t wb_next(line_st_t cur, logic rg);
        return (rg == RG_STT && cur == LN_HOLLOW) ? LN_HOT : cur;
    endfunction

    function automatic logic starts_move(line_st_t cur, logic rg);
        return (rg == RG_STT) && (cur == LN_HOT);
    endfunction

endpackage

// File: rtl/hmt_line_store.sv
module hmt_line_store
    import hmt_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int MAXW     = 4,
    parameter int SET_W    = 2,
    parameter int WAY_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_we,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             wb_we,
    input  logic [SET_W-1:0] wb_set,
    input  logic             wb_rg,
    input  logic [WAY_W-1:0] wb_way,
    input  line_st_t         wb_val,
    input  logic             mv_we,
    input  logic [SET_W-1:0] mv_set,
    input  logic [WAY_W-1:0] mv_src,
    input  logic [WAY_W-1:0] mv_dst,
    input  logic [SET_W-1:0] rd_set,
    input  logic             rd_rg,
    input  logic [WAY_W-1:0] rd_way,
    output line_st_t         rd_val,
    input  logic [SET_W-1:0] qry_set,
    input  logic             qry_rg,
    input  logic [WAY_W-1:0] qry_way,
    output line_st_t         qry_val
);

    line_st_t mem [NUM_SETS][2][MAXW];

    assign rd_val  = mem[rd_set][rd_rg][rd_way];
    assign qry_val = mem[qry_set][qry_rg][qry_way];

    // Later writes win on the same line: writeback over fill.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int r = 0; r < 2; r++)
                    for (int w = 0; w < MAXW; w++)
                        mem[s][r][w] <= LN_NONE;
        end else begin
            if (fill_we) mem[fill_set][RG_STT][fill_way] <= LN_HOLLOW;
            if (wb_we)   mem[wb_set][wb_rg][wb_way]      <= wb_val;
            if (mv_we) begin
                mem[mv_set][RG_SRAM][mv_dst] <= LN_MOVED;
                mem[mv_set][RG_STT][mv_src]  <= LN_NONE;
            end
        end
    end

endmodule

// File: rtl/hmt_rr_ptr.sv
module hmt_rr_ptr #(
    parameter int NUM_SETS  = 4,
    parameter int SRAM_WAYS = 2,
    parameter int SET_W     = 2,
    parameter int WAY_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] rd_ptr,
    input  logic             adv,
    input  logic [SET_W-1:0] adv_set
);

    localparam logic [WAY_W-1:0] LAST = WAY_W'(SRAM_WAYS - 1);

    logic [WAY_W-1:0] ptr [NUM_SETS];

    assign rd_ptr = ptr[rd_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) ptr[s] <= '0;
        end else if (adv) begin
            ptr[adv_set] <= (ptr[adv_set] == LAST) ? '0 : ptr[adv_set] + 1'b1;
        end
    end

endmodule

// File: rtl/hmt_ctrl.sv
module hmt_ctrl
    import hmt_pkg::*;
#(
    parameter int SRAM_WAYS = 2,
    parameter int STT_WAYS  = 4,
    parameter int SET_W     = 2,
    parameter int WAY_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_valid,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             fill_rg,
    input  logic             wb_valid,
    input  logic [SET_W-1:0] wb_set,
    input  logic [WAY_W-1:0] wb_way,
    input  logic             wb_rg,
    input  logic             mig_done,
    input  line_st_t         rd_val,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic             fill_we,
    output logic             wb_we,
    output line_st_t         wb_val,
    output logic             mv_we,
    output logic             busy,
    output logic             mig_req,
    output logic [SET_W-1:0] mig_set,
    output logic [WAY_W-1:0] mig_src,
    output logic [WAY_W-1:0] mig_dst,
    output logic             wb_go,
    output logic [SET_W-1:0] go_set,
    output logic             go_rg,
    output logic [WAY_W-1:0] go_way
);

    ctl_st_t fsm;
    logic    wb_in_range;
    logic    wb_ok;
    logic    start_mv;

    assign busy    = (fsm != CT_IDLE);
    assign mig_req = (fsm == CT_MOVE);

    assign fill_we = fill_valid && !busy && (fill_rg == RG_STT)
                     && (int'(fill_way) < STT_WAYS);

    assign wb_in_range = (wb_rg == RG_STT) ? (int'(wb_way) < STT_WAYS)
                                           : (int'(wb_way) < SRAM_WAYS);
    assign wb_ok    = wb_valid && !busy && wb_in_range;
    assign start_mv = wb_ok && starts_move(rd_val, wb_rg);
    assign wb_we    = wb_ok && !start_mv;
    assign wb_val   = wb_next(rd_val, wb_rg);
    assign mv_we    = (fsm == CT_MOVE) && mig_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm     <= CT_IDLE;
            mig_set <= '0;
            mig_src <= '0;
            mig_dst <= '0;
            wb_go   <= 1'b0;
            go_set  <= '0;
            go_rg   <= RG_STT;
            go_way  <= '0;
        end else begin
            wb_go <= 1'b0;
            if (start_mv) begin
                fsm     <= CT_MOVE;
                mig_set <= wb_set;
                mig_src <= wb_way;
                mig_dst <= rr_ptr;
            end else if (wb_we) begin
                wb_go  <= 1'b1;
                go_set <= wb_set;
                go_rg  <= wb_rg;
                go_way <= wb_way;
            end
            if (mv_we) begin
                fsm    <= CT_IDLE;
                wb_go  <= 1'b1;
                go_set <= mig_set;
                go_rg  <= RG_SRAM;
                go_way <= mig_dst;
            end
        end
    end

endmodule

// File: rtl/hybrid_mig_tracker.sv
module hybrid_mig_tracker
    import hmt_pkg::*;
#(
    parameter int NUM_SETS  = 4,
    parameter int SRAM_WAYS = 2,
    parameter int STT_WAYS  = 4,
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int MAXW     = (SRAM_WAYS > STT_WAYS) ? SRAM_WAYS : STT_WAYS,
    localparam int WAY_W    = $clog2(MAXW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             fill_region,
    input  logic             wb_valid,
    input  logic [SET_W-1:0] wb_set,
    input  logic [WAY_W-1:0] wb_way,
    input  logic             wb_region,
    output logic             busy,
    output logic             mig_req,
    output logic [SET_W-1:0] mig_set,
    output logic [WAY_W-1:0] mig_src_way,
    output logic [WAY_W-1:0] mig_dst_way,
    input  logic             mig_done,
    output logic             wb_go,
    output logic [SET_W-1:0] wb_go_set,
    output logic             wb_go_region,
    output logic [WAY_W-1:0] wb_go_way,
    input  logic [SET_W-1:0] qry_set,
    input  logic             qry_region,
    input  logic [WAY_W-1:0] qry_way,
    output logic [1:0]       qry_state
);

    line_st_t         rd_val;
    line_st_t         qry_val;
    line_st_t         wb_val;
    logic             fill_we;
    logic             wb_we;
    logic             mv_we;
    logic [WAY_W-1:0] rr_ptr;

    assign qry_state = qry_val;

    hmt_line_store #(
        .NUM_SETS(NUM_SETS), .MAXW(MAXW), .SET_W(SET_W), .WAY_W(WAY_W)
    ) store_i (
        .clk(clk), .rst(rst),
        .fill_we(fill_we), .fill_set(fill_set), .fill_way(fill_way),
        .wb_we(wb_we), .wb_set(wb_set), .wb_rg(wb_region), .wb_way(wb_way),
        .wb_val(wb_val),
        .mv_we(mv_we), .mv_set(mig_set), .mv_src(mig_src_way), .mv_dst(mig_dst_way),
        .rd_set(wb_set), .rd_rg(wb_region), .rd_way(wb_way), .rd_val(rd_val),
        .qry_set(qry_set), .qry_rg(qry_region), .qry_way(qry_way), .qry_val(qry_val)
    );

    hmt_rr_ptr #(
        .NUM_SETS(NUM_SETS), .SRAM_WAYS(SRAM_WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
    ) rr_i (
        .clk(clk), .rst(rst),
        .rd_set(wb_set), .rd_ptr(rr_ptr),
        .adv(mv_we), .adv_set(mig_set)
    );

    hmt_ctrl #(
        .SRAM_WAYS(SRAM_WAYS), .STT_WAYS(STT_WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
    ) ctrl_i (
        .clk(clk), .rst(rst),
        .fill_valid(fill_valid), .fill_way(fill_way), .fill_rg(fill_region),
        .wb_valid(wb_valid), .wb_set(wb_set), .wb_way(wb_way), .wb_rg(wb_region),
        .mig_done(mig_done), .rd_val(rd_val), .rr_ptr(rr_ptr),
        .fill_we(fill_we), .wb_we(wb_we), .wb_val(wb_val), .mv_we(mv_we),
        .busy(busy), .mig_req(mig_req), .mig_set(mig_set),
        .mig_src(mig_src_way), .mig_dst(mig_dst_way),
        .wb_go(wb_go), .go_set(wb_go_set), .go_rg(wb_go_region), .go_way(wb_go_way)
    );

endmodule

// File: rtl/hmt_checker.sv
module hmt_checker #(
    parameter int SRAM_WAYS = 2,
    parameter int SET_W     = 2,
    parameter int WAY_W     = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             wb_valid,
    input logic             busy,
    input logic             mig_req,
    input logic [SET_W-1:0] mig_set,
    input logic [WAY_W-1:0] mig_src_way,
    input logic [WAY_W-1:0] mig_dst_way,
    input logic             mig_done,
    input logic             wb_go,
    input logic             wb_go_region,
    input logic [WAY_W-1:0] wb_go_way
);

    p_resume_to_sram_r6: assert property (@(posedge clk) disable iff (rst)
        (mig_req && mig_done) |=> (!mig_req && wb_go && wb_go_region
                                   && (wb_go_way == $past(mig_dst_way))));

    p_move_fields_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (mig_req && !mig_done) |=> (mig_req && $stable(mig_set)
                                    && $stable(mig_src_way) && $stable(mig_dst_way)));

    p_move_needs_wb_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mig_req) |-> $past(wb_valid));

    p_no_go_when_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wb_go);

    p_dst_in_sram_r5: assert property (@(posedge clk) disable iff (rst)
        mig_req |-> (int'(mig_dst_way) < SRAM_WAYS));

    p_stray_done_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && mig_done && !wb_valid) |=> (!wb_go && !busy));

endmodule

bind hybrid_mig_tracker hmt_checker #(
    .SRAM_WAYS(SRAM_WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
) chk_i (
    .clk(clk), .rst(rst), .wb_valid(wb_valid), .busy(busy), .mig_req(mig_req),
    .mig_set(mig_set), .mig_src_way(mig_src_way), .mig_dst_way(mig_dst_way),
    .mig_done(mig_done), .wb_go(wb_go), .wb_go_region(wb_go_region),
    .wb_go_way(wb_go_way)
);

// File: tb/hybrid_mig_tracker_tb_top.sv
module hybrid_mig_tracker_tb_top;

    localparam int NS  = 4;
    localparam int SR  = 2;
    localparam int STW = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fill_valid = 1'b0;
    logic [1:0] fill_set = '0;
    logic [1:0] fill_way = '0;
    logic       fill_region = 1'b0;
    logic       wb_valid = 1'b0;
    logic [1:0] wb_set = '0;
    logic [1:0] wb_way = '0;
    logic       wb_region = 1'b0;
    logic       busy, mig_req;
    logic [1:0] mig_set, mig_src_way, mig_dst_way;
    logic       mig_done = 1'b0;
    logic       wb_go;
    logic [1:0] wb_go_set;
    logic       wb_go_region;
    logic [1:0] wb_go_way;
    logic [1:0] qry_set = '0;
    logic       qry_region = 1'b0;
    logic [1:0] qry_way = '0;
    logic [1:0] qry_state;

    int n_chk = 0;
    int n_bad = 0;
    int exp_st [NS][2][4];
    int rr [NS];

    always #4 clk = ~clk;

    hybrid_mig_tracker #(.NUM_SETS(NS), .SRAM_WAYS(SR), .STT_WAYS(STW)) dut_i (
        .clk(clk), .rst(rst),
        .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
        .fill_region(fill_region),
        .wb_valid(wb_valid), .wb_set(wb_set), .wb_way(wb_way), .wb_region(wb_region),
        .busy(busy), .mig_req(mig_req), .mig_set(mig_set),
        .mig_src_way(mig_src_way), .mig_dst_way(mig_dst_way), .mig_done(mig_done),
        .wb_go(wb_go), .wb_go_set(wb_go_set), .wb_go_region(wb_go_region),
        .wb_go_way(wb_go_way),
        .qry_set(qry_set), .qry_region(qry_region), .qry_way(qry_way),
        .qry_state(qry_state)
    );

    task automatic chk(string tag, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic look(int s, int r, int w, string tag);
        @(negedge clk);
        qry_set = 2'(s); qry_region = r[0]; qry_way = 2'(w);
        #1;
        chk(tag, int'(qry_state), exp_st[s][r][w]);
    endtask

    task automatic send_fill(int s, int w, int r);
        @(negedge clk);
        fill_valid = 1'b1; fill_set = 2'(s); fill_way = 2'(w); fill_region = r[0];
        @(negedge clk);
        fill_valid = 1'b0;
        if (r == 0 && w < STW) exp_st[s][0][w] = 1;
    endtask

    task automatic send_wb(int s, int w, int r, string tag);
        bit inr;
        int cur;
        int dst;
        inr = (r == 0) ? (w < STW) : (w < SR);
        cur = exp_st[s][r][w];
        @(negedge clk);
        wb_valid = 1'b1; wb_set = 2'(s); wb_way = 2'(w); wb_region = r[0];
        @(negedge clk);
        wb_valid = 1'b0;
        if (!inr) begin
            chk({tag, " R11 no go"}, int'(wb_go), 0);
        end else if (r == 0 && cur == 2) begin
            dst = rr[s];
            chk({tag, " R4 busy"}, int'(busy), 1);
            chk({tag, " R4 mig_req"}, int'(mig_req), 1);
            chk({tag, " R4 mig_set"}, int'(mig_set), s);
            chk({tag, " R4 src"}, int'(mig_src_way), w);
            chk({tag, " R5 dst"}, int'(mig_dst_way), dst);
            chk({tag, " R4 no go"}, int'(wb_go), 0);
            look(s, 0, w, {tag, " R4 src kept"});
            @(negedge clk);
            chk({tag, " R4 still busy"}, int'(busy), 1);
            mig_done = 1'b1;
            @(negedge clk);
            mig_done = 1'b0;
            chk({tag, " R6 go"}, int'(wb_go), 1);
            chk({tag, " R6 go region"}, int'(wb_go_region), 1);
            chk({tag, " R6 go way"}, int'(wb_go_way), dst);
            chk({tag, " R6 go set"}, int'(wb_go_set), s);
            chk({tag, " R6 busy low"}, int'(busy), 0);
            exp_st[s][1][dst] = 3;
            exp_st[s][0][w] = 0;
            rr[s] = (rr[s] + 1) % SR;
        end else begin
            chk({tag, " go"}, int'(wb_go), 1);
            chk({tag, " go set"}, int'(wb_go_set), s);
            chk({tag, " go region"}, int'(wb_go_region), r);
            chk({tag, " go way"}, int'(wb_go_way), w);
            if (r == 0 && cur == 1) exp_st[s][0][w] = 2;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            rr[s] = 0;
            for (int r = 0; r < 2; r++)
                for (int w = 0; w < 4; w++) exp_st[s][r][w] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 mig_req", int'(mig_req), 0);
        chk("R1 wb_go", int'(wb_go), 0);
        for (int s = 0; s < NS; s++)
            for (int r = 0; r < 2; r++)
                for (int w = 0; w < 4; w++) look(s, r, w, "R1 reset state");

        // R10: completion pulse with nothing pending
        @(negedge clk);
        mig_done = 1'b1;
        @(negedge clk);
        mig_done = 1'b0;
        chk("R10 no go", int'(wb_go), 0);
        chk("R10 not busy", int'(busy), 0);
        look(0, 1, 0, "R10 state");

        // R9: writeback to untouched SRAM line
        send_wb(2, 1, 1, "R9 sram");
        look(2, 1, 1, "R9 sram state");

        // Sweep every STT way of every set through the full life cycle
        for (int s = 0; s < NS; s++) begin
            for (int w = 0; w < STW; w++) begin
                send_wb(s, w, 0, "R9 stt none");
                look(s, 0, w, "R9 stt none state");
                send_fill(s, w, 0);
                look(s, 0, w, "R2 fill");
                send_wb(s, w, 0, "R3 first wb");
                look(s, 0, w, "R3 candidate");
                send_wb(s, w, 0, "move");
                look(s, 0, w, "R6 src released");
                look(s, 1, (rr[s] + SR - 1) % SR, "R6 dst moved");
                send_wb(s, 1, 1, "R7 moved wb");
                look(s, 1, 1, "R7 stays moved");
            end
        end

        // R2: fill aimed at SRAM region is ignored
        send_fill(0, 1, 1);
        look(0, 1, 1, "R2 sram fill ignored");
        look(0, 0, 1, "R2 sram fill stt line");

        // R11: out-of-range SRAM way
        send_wb(1, 3, 1, "R11 range");
        look(1, 1, 3, "R11 state");

        // R8: events during a pending move
        send_fill(3, 0, 0);
        send_wb(3, 0, 0, "R8 prep");
        send_fill(3, 1, 0);
        @(negedge clk);
        wb_valid = 1'b1; wb_set = 2'd3; wb_way = 2'd0; wb_region = 1'b0;
        @(negedge clk);
        wb_valid = 1'b0;
        chk("R8 mig_req", int'(mig_req), 1);
        chk("R5 wrap dst", int'(mig_dst_way), rr[3]);
        fill_valid = 1'b1; fill_set = 2'd3; fill_way = 2'd2; fill_region = 1'b0;
        wb_valid = 1'b1; wb_set = 2'd3; wb_way = 2'd1; wb_region = 1'b0;
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R8 still busy", int'(busy), 1);
        chk("R8 no go", int'(wb_go), 0);
        look(3, 0, 2, "R8 fill held off");
        look(3, 0, 1, "R8 wb held off");
        @(negedge clk);
        mig_done = 1'b1;
        @(negedge clk);
        mig_done = 1'b0;
        chk("R6 go region", int'(wb_go_region), 1);
        chk("R6 go way", int'(wb_go_way), rr[3]);
        exp_st[3][1][rr[3]] = 3;
        exp_st[3][0][0] = 0;
        rr[3] = (rr[3] + 1) % SR;
        @(negedge clk);
        wb_valid = 1'b0;
        chk("R8 held wb go", int'(wb_go), 1);
        chk("R8 held wb way", int'(wb_go_way), 1);
        chk("R8 held wb region", int'(wb_go_region), 0);
        exp_st[3][0][1] = 2;
        look(3, 0, 1, "R8 held wb applied");
        look(3, 0, 0, "R6 src released");

        summary();
    end

endmodule